// File: doc/BRIEF.md
# Banked Interrupt Controller with Shortcut Summary

This block gathers 72 level-sensitive interrupt lines into one processor interrupt. The lines form three groups: 8 basic sources (global numbers 0 to 7), a first bank of 32 sources (numbers 8 to 39, bank bit = number minus 8) and a second bank of 32 sources (numbers 40 to 71, bank bit = number minus 40). Each source has a mask bit. Software changes mask bits through separate set and clear registers, where only the 1 bits of the written word act. It reads the masked pending state through two bank registers and one summary word.

The summary word has three kinds of bit. Some are the basic sources themselves. Two bits flag that a bank has pending work outside its shortcut positions. The rest copy eleven selected bank sources directly. Software can therefore often find its source with a single read. A hardware resolver applies the same lookup order each cycle. It presents the winning global interrupt number with a valid flag, next to a registered combined interrupt output.

Top module: `banked_irq_ctrl`

## Requirements
- R1: After reset, all 72 mask bits are 0, and irq_o, active_valid_o and active_id_o are all 0.
- R2: A write to byte offset 0x18 sets basic mask bit b wherever wdata bit b (7:0) is 1. A write to 0x10 does the same for bank-one mask bits and a write to 0x14 for bank-two mask bits. All 32 bits of wdata are used for the banks.
- R3: A write to 0x24 clears basic mask bit b wherever wdata bit b is 1. A write to 0x1C does the same for bank one and a write to 0x20 for bank two.
- R4: Zero bits in a set or clear write leave their mask bits unchanged. Writes to 0x00, 0x04, 0x08, 0x0C and to any other offset not named in R2 or R3 change no mask bit.
- R5: Reading 0x04 returns the bank-one input lines ANDed with the bank-one mask bits. Reading 0x08 does the same for bank two. Shortcut positions are included.
- R6: Reading 0x00 returns the summary word. Bits 7:0 are the masked basic sources. Bit 8 is set if any masked bank-one source outside positions {7,9,10,18,19} is pending. Bit 9 is the same for bank two outside positions {21,22,23,24,25,30}. Bits 10 to 14 copy masked bank-one bits 7, 9, 10, 18 and 19. Bits 15 to 20 copy masked bank-two bits 21, 22, 23, 24, 25 and 30. Bits 31:21 are 0.
- R7: Reading 0x18, 0x10 or 0x14 returns the current basic, bank-one or bank-two mask bits. All other offsets read 0, including 0x0C, 0x1C, 0x20 and 0x24.
- R8: irq_o is 1 in the cycle after any masked source is pending, and 0 in the cycle after none is.
- R9: If any masked basic source is pending, active_id_o becomes the lowest such number in the next cycle, with active_valid_o = 1.
- R10: If no basic source is pending, the first pending shortcut in summary-bit order wins. The global numbers in that order are 15, 17, 18, 26, 27, 61, 62, 63, 64, 65, 70.
- R11: If no basic or shortcut source is pending, the lowest pending non-shortcut bank-one source wins (8 + bit). Failing that, the lowest pending non-shortcut bank-two source wins (40 + bit).
- R12: If no masked source is pending, active_valid_o and active_id_o are both 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| src_i | input | 72 | Interrupt lines, level sensitive, index = global number |
| irq_o | output | 1 | Combined interrupt, registered |
| active_id_o | output | 7 | Resolved global interrupt number, registered |
| active_valid_o | output | 1 | active_id_o holds a pending source |

## Verification
A corrupted mask bit shows up in the same cycle as a wrong bit in a pending or summary read. On the next clock it also shows as a wrong irq_o or a wrong resolved number. A fault in the shortcut wiring or in the exclusion of shortcut positions from the bank flags shows at offset 0x00 at once. It also shows one cycle later, because the resolver then picks a different number from the one the priority order requires. A behavioural model in the bench compares the combined output, the number, the valid flag and the read data every clock, under both directed and random traffic.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int BASIC_N = 8;
  localparam int BANK_W  = 32;
  localparam int BANKS   = 2;
  localparam int NUM_SRC = BASIC_N + BANKS * BANK_W;
  localparam int ID_W    = $clog2(NUM_SRC);
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 8;
  localparam int SC_N    = 11;
  localparam int SUM_USED = BASIC_N + BANKS + SC_N;

  localparam logic [ADDR_W-1:0] OFF_SUMMARY = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_PEND_B1 = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_PEND_B2 = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_SET_B1  = 8'h10;
  localparam logic [ADDR_W-1:0] OFF_SET_B2  = 8'h14;
  localparam logic [ADDR_W-1:0] OFF_SET_BAS = 8'h18;
  localparam logic [ADDR_W-1:0] OFF_CLR_B1  = 8'h1C;
  localparam logic [ADDR_W-1:0] OFF_CLR_B2  = 8'h20;
  localparam logic [ADDR_W-1:0] OFF_CLR_BAS = 8'h24;

  // bank positions mirrored into the summary word
  localparam logic [BANK_W-1:0] B1_SC_MASK = 32'h000C_0680;
  localparam logic [BANK_W-1:0] B2_SC_MASK = 32'h43E0_0000;

  function automatic logic [SC_N-1:0] shortcuts(input logic [BANK_W-1:0] p1,
                                                input logic [BANK_W-1:0] p2);
    return {p2[30], p2[25], p2[24], p2[23], p2[22], p2[21],
            p1[19], p1[18], p1[10], p1[9], p1[7]};
  endfunction

  function automatic logic [ID_W-1:0] shortcut_id(input int k);
    case (k)
      0:  return ID_W'(BASIC_N + 7);
      1:  return ID_W'(BASIC_N + 9);
      2:  return ID_W'(BASIC_N + 10);
      3:  return ID_W'(BASIC_N + 18);
      4:  return ID_W'(BASIC_N + 19);
      5:  return ID_W'(BASIC_N + BANK_W + 21);
      6:  return ID_W'(BASIC_N + BANK_W + 22);
      7:  return ID_W'(BASIC_N + BANK_W + 23);
      8:  return ID_W'(BASIC_N + BANK_W + 24);
      9:  return ID_W'(BASIC_N + BANK_W + 25);
      default: return ID_W'(BASIC_N + BANK_W + 30);
    endcase
  endfunction
endpackage

// File: rtl/irqc_mask_bank.sv
module irqc_mask_bank #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         set_i,
  input  logic         clr_i,
  input  logic [W-1:0] bits_i,
  output logic [W-1:0] en_o
);
  logic [W-1:0] en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    en_q <= '0;
    else if (set_i) en_q <= en_q | bits_i;
    else if (clr_i) en_q <= en_q & ~bits_i;
  end

  assign en_o = en_q;

  assert_set_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> ((en_q & $past(bits_i)) == $past(bits_i)));
  assert_clr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> ((en_q & $past(bits_i)) == '0));
  assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_i && !clr_i) |=> $stable(en_q));
endmodule

// File: rtl/irqc_summary.sv
module irqc_summary
  import irqc_pkg::*;
(
  input  logic [BASIC_N-1:0] basic_i,
  input  logic [BANK_W-1:0]  b1_i,
  input  logic [BANK_W-1:0]  b2_i,
  output logic [SC_N-1:0]    sc_o,
  output logic [BANK_W-1:0]  rest1_o,
  output logic [BANK_W-1:0]  rest2_o,
  output logic [DATA_W-1:0]  summary_o
);
  assign sc_o    = shortcuts(b1_i, b2_i);
  assign rest1_o = b1_i & ~B1_SC_MASK;
  assign rest2_o = b2_i & ~B2_SC_MASK;
  assign summary_o = {{(DATA_W-SUM_USED){1'b0}}, sc_o, |rest2_o, |rest1_o, basic_i};
endmodule

// File: rtl/irqc_resolver.sv
module irqc_resolver
  import irqc_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [BASIC_N-1:0] basic_i,
  input  logic [SC_N-1:0]    sc_i,
  input  logic [BANK_W-1:0]  rest1_i,
  input  logic [BANK_W-1:0]  rest2_i,
  output logic [ID_W-1:0]    id_o,
  output logic               valid_o
);
  logic [ID_W-1:0] nxt_id;
  logic            nxt_v;

  function automatic logic [ID_W-1:0] lowest(input logic [BANK_W-1:0] v);
    logic [ID_W-1:0] r;
    r = '0;
    for (int i = BANK_W - 1; i >= 0; i--) if (v[i]) r = ID_W'(i);
    return r;
  endfunction

  // later branches override earlier ones: highest priority last
  always_comb begin
    nxt_id = '0;
    nxt_v  = 1'b0;
    if (|rest2_i) begin
      nxt_v  = 1'b1;
      nxt_id = ID_W'(BASIC_N + BANK_W) + lowest(rest2_i);
    end
    if (|rest1_i) begin
      nxt_v  = 1'b1;
      nxt_id = ID_W'(BASIC_N) + lowest(rest1_i);
    end
    if (|sc_i) begin
      nxt_v = 1'b1;
      for (int k = SC_N - 1; k >= 0; k--) if (sc_i[k]) nxt_id = shortcut_id(k);
    end
    if (|basic_i) begin
      nxt_v  = 1'b1;
      nxt_id = lowest({{(BANK_W-BASIC_N){1'b0}}, basic_i});
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      id_o    <= '0;
      valid_o <= 1'b0;
    end else begin
      id_o    <= nxt_id;
      valid_o <= nxt_v;
    end
  end

  assert_basic_first_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|basic_i) |=> (valid_o && (id_o < ID_W'(BASIC_N))));
  assert_bank2_last_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(|basic_i) && !(|sc_i) && !(|rest1_i) && (|rest2_i))
      |=> (valid_o && (id_o >= ID_W'(BASIC_N + BANK_W))));
  assert_idle_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(|basic_i) && !(|sc_i) && !(|rest1_i) && !(|rest2_i))
      |=> (!valid_o && (id_o == '0)));
endmodule

// File: rtl/banked_irq_ctrl.sv
module banked_irq_ctrl
  import irqc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [NUM_SRC-1:0] src_i,
  output logic              irq_o,
  output logic [ID_W-1:0]   active_id_o,
  output logic              active_valid_o
);
  localparam logic [ADDR_W-1:0] SET_OFF [BANKS] = '{OFF_SET_B1, OFF_SET_B2};
  localparam logic [ADDR_W-1:0] CLR_OFF [BANKS] = '{OFF_CLR_B1, OFF_CLR_B2};

  logic [BASIC_N-1:0] basic_en, basic_pend;
  logic [BANK_W-1:0]  bank_en   [BANKS];
  logic [BANK_W-1:0]  bank_pend [BANKS];
  logic [SC_N-1:0]    sc;
  logic [BANK_W-1:0]  rest1, rest2;
  logic [DATA_W-1:0]  summary;
  logic               irq_q;

  irqc_mask_bank #(.W(BASIC_N)) u_basic (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (we_i && addr_i == OFF_SET_BAS),
    .clr_i  (we_i && addr_i == OFF_CLR_BAS),
    .bits_i (wdata_i[BASIC_N-1:0]),
    .en_o   (basic_en)
  );
  assign basic_pend = src_i[BASIC_N-1:0] & basic_en;

  for (genvar g = 0; g < BANKS; g++) begin : g_bank
    irqc_mask_bank #(.W(BANK_W)) u_mask (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (we_i && addr_i == SET_OFF[g]),
      .clr_i  (we_i && addr_i == CLR_OFF[g]),
      .bits_i (wdata_i[BANK_W-1:0]),
      .en_o   (bank_en[g])
    );
    assign bank_pend[g] = src_i[BASIC_N + g*BANK_W +: BANK_W] & bank_en[g];
  end

  irqc_summary u_summary (
    .basic_i   (basic_pend),
    .b1_i      (bank_pend[0]),
    .b2_i      (bank_pend[1]),
    .sc_o      (sc),
    .rest1_o   (rest1),
    .rest2_o   (rest2),
    .summary_o (summary)
  );

  irqc_resolver u_resolver (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .basic_i (basic_pend),
    .sc_i    (sc),
    .rest1_i (rest1),
    .rest2_i (rest2),
    .id_o    (active_id_o),
    .valid_o (active_valid_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |{basic_pend, bank_pend[0], bank_pend[1]};
  end
  assign irq_o = irq_q;

  always_comb begin
    case (addr_i)
      OFF_SUMMARY: rdata_o = summary;
      OFF_PEND_B1: rdata_o = bank_pend[0];
      OFF_PEND_B2: rdata_o = bank_pend[1];
      OFF_SET_B1:  rdata_o = bank_en[0];
      OFF_SET_B2:  rdata_o = bank_en[1];
      OFF_SET_BAS: rdata_o = {{(DATA_W-BASIC_N){1'b0}}, basic_en};
      default:     rdata_o = '0;
    endcase
  end

  assert_irq_matches_valid_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == active_valid_o);
endmodule

// File: tb/sim_banked_irq_ctrl.sv
module sim_banked_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [71:0] src = '0;
  logic [31:0] rdata;
  logic        irq;
  logic [6:0]  act_id;
  logic        act_v;

  int checks = 0;
  int errors = 0;
  bit en_m [72];
  int sc_ids [11] = '{15, 17, 18, 26, 27, 61, 62, 63, 64, 65, 70};
  logic [7:0] addr_pool [14] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h18,
                                 8'h1C, 8'h20, 8'h24, 8'h28, 8'h3C, 8'h02, 8'hFC};

  always #5 clk = ~clk;

  banked_irq_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .src_i(src), .irq_o(irq), .active_id_o(act_id),
    .active_valid_o(act_v)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit is_sc(int n);
    foreach (sc_ids[k]) if (sc_ids[k] == n) return 1'b1;
    return 1'b0;
  endfunction

  function automatic bit pend(int n);
    return src[n] & en_m[n];
  endfunction

  function automatic logic [31:0] model_read(logic [7:0] a);
    logic [31:0] r;
    r = '0;
    case (a)
      8'h00: begin
        for (int i = 0; i < 8; i++) r[i] = pend(i);
        for (int b = 0; b < 32; b++) begin
          if (!is_sc(8 + b) && pend(8 + b)) r[8] = 1'b1;
          if (!is_sc(40 + b) && pend(40 + b)) r[9] = 1'b1;
        end
        for (int k = 0; k < 11; k++) r[10 + k] = pend(sc_ids[k]);
      end
      8'h04: for (int b = 0; b < 32; b++) r[b] = pend(8 + b);
      8'h08: for (int b = 0; b < 32; b++) r[b] = pend(40 + b);
      8'h10: for (int b = 0; b < 32; b++) r[b] = en_m[8 + b];
      8'h14: for (int b = 0; b < 32; b++) r[b] = en_m[40 + b];
      8'h18: for (int b = 0; b < 8; b++) r[b] = en_m[b];
      default: r = '0;
    endcase
    return r;
  endfunction

  // returns id, -1 if none; tag names the deciding requirement
  function automatic int model_resolve(output string tag);
    for (int i = 0; i < 8; i++) if (pend(i)) begin tag = "R9"; return i; end
    foreach (sc_ids[k]) if (pend(sc_ids[k])) begin tag = "R10"; return sc_ids[k]; end
    for (int i = 8; i < 72; i++)
      if (!is_sc(i) && pend(i)) begin tag = "R11"; return i; end
    tag = "R12";
    return -1;
  endfunction

  task automatic model_write(input logic [7:0] a, input logic [31:0] d);
    for (int b = 0; b < 32; b++) if (d[b]) begin
      case (a)
        8'h18: if (b < 8) en_m[b] = 1'b1;
        8'h24: if (b < 8) en_m[b] = 1'b0;
        8'h10: en_m[8 + b]  = 1'b1;
        8'h1C: en_m[8 + b]  = 1'b0;
        8'h14: en_m[40 + b] = 1'b1;
        8'h20: en_m[40 + b] = 1'b0;
        default: ;
      endcase
    end
  endtask

  task automatic step(input bit w, input logic [7:0] a, input logic [31:0] d,
                      input logic [71:0] s);
    string rtag, dtag;
    int eid;
    bit eirq;
    logic [31:0] erd;
    we = w; addr = a; wdata = d; src = s;
    eid  = model_resolve(rtag);
    eirq = (eid >= 0);
    @(posedge clk);
    if (w) model_write(a, d);
    erd = model_read(a);
    @(negedge clk);
    chk("R8 irq", 32'(irq), 32'(eirq));
    chk({rtag, " valid"}, 32'(act_v), 32'(eirq));
    chk({rtag, " id"}, 32'(act_id), eirq ? 32'(eid) : 32'd0);
    case (a)
      8'h00: dtag = "R6 summary";
      8'h04, 8'h08: dtag = "R5 bank pending";
      default: dtag = "R7 readback";
    endcase
    chk(dtag, rdata, erd);
  endtask

  task automatic rd(input logic [7:0] a, input logic [71:0] s);
    step(1'b0, a, 32'h0, s);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [71:0] s;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", 32'(irq), 32'd0);
    chk("R1 valid", 32'(act_v), 32'd0);
    chk("R1 id", 32'(act_id), 32'd0);
    s = '1;
    rd(8'h10, s); chk("R1 bank1 mask", rdata, 32'h0);
    rd(8'h14, s); chk("R1 bank2 mask", rdata, 32'h0);
    rd(8'h18, s); chk("R1 basic mask", rdata, 32'h0);

    // R2 set, R4 zero bits and ignored offsets
    step(1'b1, 8'h10, 32'h0010_0080, s);
    rd(8'h10, s); chk("R2 bank1 set", rdata, 32'h0010_0080);
    step(1'b1, 8'h10, 32'h0, s);
    step(1'b1, 8'h0C, 32'hFFFF_FFFF, s);
    step(1'b1, 8'h00, 32'hFFFF_FFFF, s);
    step(1'b1, 8'h28, 32'hFFFF_FFFF, s);
    rd(8'h10, s); chk("R4 bank1 unchanged", rdata, 32'h0010_0080);
    rd(8'h14, s); chk("R4 bank2 unchanged", rdata, 32'h0);
    // R3 clear
    step(1'b1, 8'h1C, 32'h0000_0080, s);
    rd(8'h10, s); chk("R3 bank1 clear", rdata, 32'h0010_0000);
    step(1'b1, 8'h1C, 32'hFFFF_FFFF, s);

    // R11 bank2 lowest non-shortcut, then shortcut precedence R10
    step(1'b1, 8'h14, 32'hFFFF_FFFF, 72'h0);
    s = 72'h0; s[40 + 21] = 1'b1; s[40 + 26] = 1'b1;
    rd(8'h00, s); rd(8'h00, s);
    chk("R10 id 61", 32'(act_id), 32'd61);
    chk("R6 summary bit9 and bit15", rdata, 32'h0000_8200);
    s = 72'h0; s[40 + 30] = 1'b1; s[40 + 3] = 1'b1;
    rd(8'h08, s); rd(8'h08, s);
    chk("R10 id 70 over bank", 32'(act_id), 32'd70);
    s[40 + 30] = 1'b0;
    rd(8'h08, s); rd(8'h08, s);
    chk("R11 id 43", 32'(act_id), 32'd43);
    // R9 basic first
    step(1'b1, 8'h18, 32'hFFFF_FF24, s);
    s[2] = 1'b1; s[5] = 1'b1;
    rd(8'h18, s); rd(8'h18, s);
    chk("R9 id 2", 32'(act_id), 32'd2);
    chk("R7 basic mask", rdata, 32'h0000_0024);
    step(1'b1, 8'h24, 32'h0000_0004, s);
    rd(8'h24, s);
    chk("R9 id 5", 32'(act_id), 32'd5);
    chk("R7 clear offset reads zero", rdata, 32'h0);
    // R12 nothing pending
    rd(8'h00, 72'h0); rd(8'h00, 72'h0);
    chk("R12 valid", 32'(act_v), 32'd0);

    // random traffic
    for (int n = 0; n < 3000; n++) begin
      logic [71:0] rs;
      logic [31:0] rw;
      bit w;
      rs = {$urandom, $urandom, $urandom} & {$urandom, $urandom, $urandom};
      rw = $urandom & $urandom;
      w  = ($urandom % 3) == 0;
      step(w, addr_pool[$urandom % 14], rw, rs);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule